// File: doc/BRIEF.md
# Extraction Word-Stream Frame Decoder

This block sits behind a switch CPU extraction queue that hands out frames as a stream of 32-bit words. Every frame opens with a fixed number of internal header words. These are forwarded untouched and flagged as header. The body follows, and framing inside it is in-band. A small set of reserved 32-bit values signals end of frame (together with how many bytes of the last data word are unused), pruning, abort and "no data yet". A further reserved value escapes a literal data word that happens to equal a reserved value.

The decoder strips the control words and forwards the body words one beat behind the input. The delay exists because a data word is only known to be the last one when the following word arrives. On the final beat it reports a byte-enable mask, a status (good, aborted or pruned) and the frame length without the 4-byte FCS. An optional byte-swap mode reverses the byte order of each word before it is compared with the reserved values. The data itself is forwarded as received. Both sides use valid/ready handshakes. Output beats are registered and are held while the consumer stalls.

Top module: `xtr_frame_decoder`

## Requirements
- R1: The first HDR_WORDS accepted words of each frame are output unchanged with `out_hdr` high, `out_last` low and `out_be` = 4'hF, and are never decoded as control values.
- R2: In the body, any word outside 0x80000000..0x80000007 (after the optional swap) is data and adds 4 bytes to the count. It is output as a non-last beat with `out_be` = 4'hF once the next body word shows that it is not the last.
- R3: A body value 0x8000000u (u = 0..3, low two bits) ends the frame with status 0 (good). The final beat carries the held data word with `out_be` bits [3-u:0] set (byte lane i = bits 8i+7:8i), and the count is reduced by u. If no data word is held, the final beat has `out_data` = 0 and `out_be` = 0.
- R4: The body value 0x80000004 (prune) flushes any held word as a non-last beat. The next word is then taken as the final data word (`out_be` = 4'hF, adds 4 bytes), and status is 2 (pruned).
- R5: The body value 0x80000005 (abort) ends the frame at once with status 1. The final beat carries the held word with `out_be` = 4'hF, or `out_data` = 0 and `out_be` = 0 if none is held.
- R6: The body value 0x80000006 (escape) produces nothing itself. The next word is taken as literal data, adds 4 bytes, and is never treated as a control value.
- R7: The body value 0x80000007 (not ready) is dropped. It produces no beat and leaves the byte count and held word unchanged.
- R8: With `swap_en` high, each body word is byte-reversed only for the comparison against the control values. Data beats carry the word exactly as received.
- R9: On the final beat, `out_len` equals the frame's byte count minus 4, floored at 0. `out_stat` and `out_len` are meaningful only when `out_last` is high.
- R10: While `out_valid` is high and `out_ready` is low, the output beat stays unchanged and `in_ready` is low. `in_ready` is high whenever the output register is empty or being consumed.
- R11: A synchronous reset clears `out_valid` and restarts decoding at the first header word, discarding any partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Compare control values on the byte-reversed word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| in_data | input | 32 | Input word from the extraction queue |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 32 | Header or frame data word |
| out_hdr | output | 1 | Beat is a header word |
| out_last | output | 1 | Final beat of the frame |
| out_be | output | 4 | Valid byte lanes of the beat |
| out_stat | output | 2 | Frame status on the final beat: 0 good, 1 aborted, 2 pruned |
| out_len | output | LEN_W | Frame length without FCS on the final beat |

## Verification
The bench builds the decoder with HDR_WORDS = 3 and LEN_W = 16. The short header means many small frames fit in one run, so every ending fits in: all four unused-byte counts, abort with and without a held word, prune, and end of frame directly after the header. It also puts the saturating length floor within reach. Some header words equal reserved values, which shows they are not decoded. Random input gaps and random consumer stalls exercise the hold behaviour. A mid-frame reset and a swapped-comparison segment, where the raw reserved values become plain data, complete the run.

// File: rtl/xtr_dec_pkg.sv
package xtr_dec_pkg;
  typedef enum logic [2:0] {
    K_DATA, K_EOF, K_PRUNE, K_ABORT, K_ESC, K_NRDY
  } word_kind_e;

  typedef enum logic [1:0] {
    FS_GOOD  = 2'd0,
    FS_ABORT = 2'd1,
    FS_PRUNE = 2'd2
  } frame_stat_e;

  typedef enum logic [1:0] {
    PH_HDR, PH_BODY, PH_LIT, PH_PRLIT
  } phase_e;

  localparam logic [28:0] CTRL_PREFIX = 29'h1000_0000;
endpackage

// File: rtl/xtr_word_classify.sv
module xtr_word_classify
  import xtr_dec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              swap_en,
  output word_kind_e        kind,
  output logic [1:0]        unused_bytes
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] reversed;
  logic [WORD_W-1:0] cmp;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_rev
      assign reversed[8*gi +: 8] = word[8*(NBYTES-1-gi) +: 8];
    end
  endgenerate

  assign cmp          = swap_en ? reversed : word;
  assign unused_bytes = cmp[1:0];

  always_comb begin
    kind = K_DATA;
    if (cmp[WORD_W-1:3] == CTRL_PREFIX) begin
      case (cmp[2:0])
        3'd4:    kind = K_PRUNE;
        3'd5:    kind = K_ABORT;
        3'd6:    kind = K_ESC;
        3'd7:    kind = K_NRDY;
        default: kind = K_EOF;
      endcase
    end
  end
endmodule

// File: rtl/xtr_tail_calc.sv
module xtr_tail_calc #(
  parameter int LEN_W = 16,
  parameter int FCS_BYTES = 4
) (
  input  logic [LEN_W-1:0] body_bytes,
  input  logic [1:0]       unused_bytes,
  input  logic             has_data,
  output logic [3:0]       last_be,
  output logic [LEN_W-1:0] len_no_fcs
);
  localparam logic [LEN_W-1:0] FCS_L = LEN_W'(FCS_BYTES);

  logic [LEN_W-1:0] frame_bytes;

  assign last_be     = has_data ? (4'hF >> unused_bytes) : 4'h0;
  assign frame_bytes = has_data ? (body_bytes - LEN_W'(unused_bytes)) : body_bytes;
  assign len_no_fcs  = (frame_bytes > FCS_L) ? (frame_bytes - FCS_L) : '0;
endmodule

// File: rtl/xtr_frame_decoder.sv
module xtr_frame_decoder
  import xtr_dec_pkg::*;
#(
  parameter int HDR_WORDS = 9,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_hdr,
  output logic             out_last,
  output logic [3:0]       out_be,
  output logic [1:0]       out_stat,
  output logic [LEN_W-1:0] out_len
);
  localparam int HC_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HDR_WORDS - 1);
  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  phase_e           phase;
  logic [HC_W-1:0]  hcnt;
  logic             pend_v;
  logic [31:0]      pend_data;
  logic [LEN_W-1:0] bytes;

  word_kind_e       kind;
  logic [1:0]       unused;
  logic             take, is_data;

  logic [LEN_W-1:0] t_bytes;
  logic [1:0]       t_unused;
  logic             t_has;
  logic [3:0]       t_be;
  logic [LEN_W-1:0] t_len;

  logic             emit, e_hdr, e_last;
  logic [31:0]      e_data;
  logic [3:0]       e_be;
  frame_stat_e      e_stat;
  logic [LEN_W-1:0] e_len;

  xtr_word_classify #(.WORD_W(32)) u_classify (
    .word(in_data), .swap_en(swap_en), .kind(kind), .unused_bytes(unused)
  );

  assign t_bytes  = (phase == PH_PRLIT) ? (bytes + WORD_BYTES) : bytes;
  assign t_unused = (phase == PH_BODY && kind == K_EOF) ? unused : 2'd0;
  assign t_has    = (phase == PH_PRLIT) ? 1'b1 : pend_v;

  xtr_tail_calc #(.LEN_W(LEN_W), .FCS_BYTES(4)) u_tail (
    .body_bytes(t_bytes), .unused_bytes(t_unused), .has_data(t_has),
    .last_be(t_be), .len_no_fcs(t_len)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign is_data  = (phase == PH_LIT) || (phase == PH_BODY && kind == K_DATA);

  always_comb begin
    emit   = 1'b0;
    e_hdr  = 1'b0;
    e_last = 1'b0;
    e_data = pend_data;
    e_be   = 4'hF;
    e_stat = FS_GOOD;
    e_len  = '0;
    case (phase)
      PH_HDR: begin
        emit   = 1'b1;
        e_hdr  = 1'b1;
        e_data = in_data;
      end
      PH_LIT: emit = pend_v;
      PH_PRLIT: begin
        emit   = 1'b1;
        e_last = 1'b1;
        e_data = in_data;
        e_be   = t_be;
        e_stat = FS_PRUNE;
        e_len  = t_len;
      end
      default: begin
        case (kind)
          K_DATA, K_PRUNE: emit = pend_v;
          K_EOF, K_ABORT: begin
            emit   = 1'b1;
            e_last = 1'b1;
            e_data = pend_v ? pend_data : 32'h0;
            e_be   = t_be;
            e_stat = (kind == K_ABORT) ? FS_ABORT : FS_GOOD;
            e_len  = t_len;
          end
          default: emit = 1'b0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_hdr   <= 1'b0;
      out_last  <= 1'b0;
      out_be    <= '0;
      out_stat  <= '0;
      out_len   <= '0;
    end else if (take && emit) begin
      out_valid <= 1'b1;
      out_data  <= e_data;
      out_hdr   <= e_hdr;
      out_last  <= e_last;
      out_be    <= e_be;
      out_stat  <= e_stat;
      out_len   <= e_len;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HDR;
      hcnt      <= '0;
      pend_v    <= 1'b0;
      pend_data <= '0;
      bytes     <= '0;
    end else if (take) begin
      case (phase)
        PH_HDR: begin
          if (hcnt == HC_LAST) begin
            hcnt   <= '0;
            phase  <= PH_BODY;
            bytes  <= '0;
            pend_v <= 1'b0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        PH_PRLIT: begin
          phase  <= PH_HDR;
          pend_v <= 1'b0;
        end
        default: begin
          if (is_data) begin
            pend_data <= in_data;
            pend_v    <= 1'b1;
            bytes     <= bytes + WORD_BYTES;
            phase     <= PH_BODY;
          end else begin
            case (kind)
              K_ESC:   phase <= PH_LIT;
              K_PRUNE: begin
                phase  <= PH_PRLIT;
                pend_v <= 1'b0;
              end
              K_EOF, K_ABORT: begin
                phase  <= PH_HDR;
                pend_v <= 1'b0;
              end
              default: phase <= PH_BODY;
            endcase
          end
        end
      endcase
    end
  end

  // Output beat is frozen while the consumer stalls (R10)
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_be));
  // Header beats are full and never close a frame (R1)
  assert_hdr_shape_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_hdr |-> !out_last && out_be == 4'hF);
  // Non-final beats carry all four lanes (R2)
  assert_mid_full_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |-> out_be == 4'hF);
  // Final byte mask is a contiguous low-lane run (R3)
  assert_be_shape_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> out_be inside {4'h0, 4'h1, 4'h3, 4'h7, 4'hF});
  // Pruned frames end on a full word (R4)
  assert_prune_full_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && out_stat == 2'd2 |-> out_be == 4'hF);
  // Aborted frames end on a full word or an empty beat (R5)
  assert_abort_be_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && out_stat == 2'd1 |-> out_be inside {4'h0, 4'hF});
  // A not-ready word leaves the count untouched (R7)
  assert_nrdy_count_R7: assert property (@(posedge clk) disable iff (rst)
    take && phase == PH_BODY && kind == K_NRDY |=> $stable(bytes) && $stable(pend_v));
  // An empty final beat reports zero length (R9)
  assert_empty_len_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && out_be == 4'h0 |-> out_len == '0);
endmodule

// File: tb/xtr_frame_decoder_bench.sv
`timescale 1ns/1ps
module xtr_frame_decoder_bench;
  localparam int HDR = 3;
  localparam int LW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swap_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [31:0] out_data;
  logic out_hdr, out_last;
  logic [3:0] out_be;
  logic [1:0] out_stat;
  logic [LW-1:0] out_len;

  always #2.5 clk = ~clk;

  xtr_frame_decoder #(.HDR_WORDS(HDR), .LEN_W(LW)) u_xtr_frame_decoder (
    .clk(clk), .rst(rst), .swap_en(swap_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_hdr(out_hdr), .out_last(out_last), .out_be(out_be),
    .out_stat(out_stat), .out_len(out_len)
  );

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] d; bit h; bit l; logic [3:0] be; int st; int len; string tag;
  } beat_t;
  beat_t exp_q[$];
  logic [31:0] words[$];
  int idx = 0;

  int m_phase = 0, m_hcnt = 0, m_bytes = 0;
  bit m_pv = 0, m_swap = 0;
  logic [31:0] m_pd = '0;
  string m_end_tag = "R3";

  function automatic int lenf(int b);
    return (b > 4) ? b - 4 : 0;
  endfunction

  task automatic push(logic [31:0] d, bit h, bit l, logic [3:0] be, int st, int len, string tag);
    beat_t b;
    b.d = d; b.h = h; b.l = l; b.be = be; b.st = st; b.len = len; b.tag = tag;
    exp_q.push_back(b);
  endtask

  task automatic take_data(logic [31:0] w);
    if (m_pv) push(m_pd, 0, 0, 4'hF, 0, 0, "R2");
    m_pd = w; m_pv = 1; m_bytes += 4;
  endtask

  task automatic put(logic [31:0] w);
    logic [31:0] c;
    int code;
    words.push_back(w);
    c = m_swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    code = int'(c[2:0]);
    case (m_phase)
      0: begin
        push(w, 1, 0, 4'hF, 0, 0, "R1");
        m_hcnt++;
        if (m_hcnt == HDR) begin m_hcnt = 0; m_phase = 1; m_pv = 0; m_bytes = 0; end
      end
      2: begin take_data(w); m_phase = 1; end
      3: begin
        m_bytes += 4;
        push(w, 0, 1, 4'hF, 2, lenf(m_bytes), "R4");
        m_phase = 0; m_pv = 0;
      end
      default: begin
        if (c[31:3] != 29'h1000_0000) take_data(w);
        else if (code <= 3) begin
          if (m_pv) push(m_pd, 0, 1, 4'hF >> code, 0, lenf(m_bytes - code), m_end_tag);
          else      push(32'h0, 0, 1, 4'h0, 0, lenf(m_bytes), m_end_tag);
          m_pv = 0; m_phase = 0;
        end else if (code == 4) begin
          if (m_pv) push(m_pd, 0, 0, 4'hF, 0, 0, "R4");
          m_pv = 0; m_phase = 3;
        end else if (code == 5) begin
          push(m_pv ? m_pd : 32'h0, 0, 1, m_pv ? 4'hF : 4'h0, 1, lenf(m_bytes), "R5");
          m_pv = 0; m_phase = 0;
        end else if (code == 6) m_phase = 2;
      end
    endcase
  endtask

  task automatic hdr3(logic [31:0] a);
    put(a); put(a + 1); put(32'h8000_0005);
  endtask

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  bit stall_prev = 0;
  logic [31:0] sd;
  logic sl;
  logic [3:0] sbe;

  task automatic run_stream();
    int cyc = 0;
    bit fire_in, fire_out;
    beat_t b;
    while (!(idx == words.size() && exp_q.size() == 0 && !out_valid)) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(0, "R10", "watchdog expired", cyc, 0);
        return;
      end
      chk(in_ready == (!out_valid || out_ready), "R10", "in_ready", in_ready, !out_valid || out_ready);
      if (stall_prev)
        chk(out_valid && out_data == sd && out_last == sl && out_be == sbe, "R10", "held beat",
            out_data, sd);
      stall_prev = out_valid && !out_ready;
      sd = out_data; sl = out_last; sbe = out_be;
      fire_in  = in_valid && in_ready;
      fire_out = out_valid && out_ready;
      if (fire_out) begin
        if (exp_q.size() == 0) chk(0, "R2", "unexpected beat", out_data, 0);
        else begin
          b = exp_q.pop_front();
          chk(out_data == b.d, b.tag, "data", out_data, b.d);
          chk(out_hdr == b.h && out_last == b.l, b.tag, "hdr/last", {out_hdr, out_last}, {b.h, b.l});
          chk(out_be == b.be, b.tag, "be", out_be, b.be);
          if (b.l) begin
            chk(int'(out_stat) == b.st, b.tag, "stat", out_stat, b.st);
            chk(int'(out_len) == b.len, (b.tag == "R4" || b.tag == "R5") ? b.tag : "R9", "len",
                out_len, b.len);
          end
        end
      end
      @(posedge clk);
      #1;
      if (fire_in) idx++;
      in_valid  = (idx < words.size()) && ($urandom_range(0, 3) != 0);
      in_data   = (idx < words.size()) ? words[idx] : 32'h0;
      out_ready = ($urandom_range(0, 2) != 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R11", "out_valid after reset", out_valid, 0);

    // unswapped frames
    m_end_tag = "R3";
    hdr3(32'h1000); put(32'hA1); put(32'hA2); put(32'hA3); put(32'h8000_0002);
    hdr3(32'h2000); put(32'hB1); put(32'h8000_0000);
    hdr3(32'h2100); put(32'hB5); put(32'hB6); put(32'h8000_0003);
    m_end_tag = "R6";
    hdr3(32'h3000); put(32'hC1); put(32'h8000_0007); put(32'hC2);
    put(32'h8000_0006); put(32'h8000_0000); put(32'h8000_0006); put(32'h8000_0007);
    put(32'h8000_0001);
    m_end_tag = "R7";
    hdr3(32'h3100); put(32'h8000_0007); put(32'hC8); put(32'h8000_0007); put(32'h8000_0000);
    hdr3(32'h4000); put(32'hD1); put(32'hD2); put(32'h8000_0004); put(32'h8000_0005);
    hdr3(32'h4100); put(32'h8000_0004); put(32'hD9);
    hdr3(32'h5000); put(32'hE1); put(32'hE2); put(32'h8000_0005);
    hdr3(32'h5100); put(32'h8000_0005);
    m_end_tag = "R9";
    hdr3(32'h6000); put(32'h8000_0003);
    hdr3(32'h6100); put(32'hF1); put(32'h8000_0001);
    hdr3(32'h6200); put(32'hF2); put(32'hF3); put(32'h8000_0001);
    run_stream();

    // swapped comparison
    swap_en = 1'b1; m_swap = 1; m_end_tag = "R8";
    hdr3(32'h7000); put(32'h8000_0002); put(32'h1122_3344); put(32'h0200_0080);
    hdr3(32'h7100); put(32'h55); put(32'h0600_0080); put(32'h0500_0080); put(32'h0000_0080);
    hdr3(32'h7200); put(32'h66); put(32'h0400_0080); put(32'h77);
    run_stream();

    // mid-frame reset
    swap_en = 1'b0; m_swap = 0;
    hdr3(32'h8000); put(32'h91); put(32'h92);
    run_stream();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    m_phase = 0; m_hcnt = 0; m_pv = 0; m_bytes = 0;
    @(negedge clk);
    chk(!out_valid, "R11", "out_valid after mid-frame reset", out_valid, 0);
    m_end_tag = "R11";
    put(32'h8000_0006); put(32'h8000_0000); put(32'h8000_0004); put(32'hAB); put(32'h8000_0000);
    run_stream();

    chk(exp_q.size() == 0, "R2", "beats left over", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule